// File: doc/BRIEF.md
# Keypad Wake-Up Edge Detector

This block watches eight general-purpose input pins for a high-to-low transition, which is how a key press shows itself on a keypad with pull-ups. Each pin is first brought into the clock domain through a short synchronizer chain. A small per-pin tracker state machine then turns each transition into a one-cycle detection pulse. Per-pin enables from an 8-bit control register select which pins count. The four low pins share a single enable bit. Each of the four high pins has an enable bit of its own.

All enabled detections merge into one wake pulse, which releases standby and is not masked. The same detections set a sticky request flag. An interrupt request leaves the block when the flag is set and the mask bit is clear. Software reaches the control register, the flag and the mask through a small register port with a write strobe. Read data is combinational from the address. The pin's direction does not affect detection.

Per-pin tracker states are EDG_START, EDG_HIGH and EDG_LOW. EDG_START leaves for EDG_HIGH or EDG_LOW according to the first sampled level. EDG_HIGH goes to EDG_LOW when the level drops, and that transition is the one that emits the pulse. EDG_LOW returns to EDG_HIGH when the level rises. The flag states are FLG_IDLE and FLG_PEND. FLG_IDLE moves to FLG_PEND on any enabled detection. FLG_PEND moves back to FLG_IDLE only when software writes 0 and no detection arrives in that cycle.

Top module: `kbw_top`

## Requirements
- R1: After reset the control register reads 0x00, the flag reads 0, the mask reads 1, and both `irq` and `wake` are low.
- R2: Address 0 is the control register. Bits 1 to 3 ignore writes and always read 0, so a write of 0xFF reads back 0xF1.
- R3: Control bit 0 enables detection on pins 0, 1, 2 and 3 together. With it clear, falls on those pins cause no wake and no flag.
- R4: Control bit n, for n from 4 to 7, enables detection on pin n only. It has no effect on any other high pin.
- R5: Only a high-to-low transition of an enabled pin is an event. Rising transitions, steady levels and falls on disabled pins produce neither wake nor flag.
- R6: `wake` is high for exactly one clock cycle per event. That cycle follows the second rising clock edge after the pin goes low.
- R7: Address 1, bit 0 is the request flag. An event sets it one cycle after the wake pulse. It stays set until software writes 0. Writing 1 to it has no effect.
- R8: If a software clear of the flag lands in the same cycle as an event, the flag stays set.
- R9: Address 2, bit 0 is the mask. `irq` is high exactly when the flag is set and the mask is 0. `wake` pulses regardless of the mask.
- R10: Address 3 reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_pins | input | 8 | Raw pin levels, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 flag, 2 mask, 3 unused |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| irq | output | 1 | Interrupt request: flag and not mask |
| wake | output | 1 | One-cycle standby-release pulse |

## Verification
A table of vectors pairs a control value with a starting pin pattern and an ending pin pattern. Some vectors drop a single enabled low pin or a single enabled high pin. Others drop a pin that is disabled, drop a neighbour of an enabled high pin, or raise all pins. One vector mixes rising low pins with a falling high pin. Together these separate the grouped enable from the individual enables, and falling from rising.

Directed tests pin down the exact cycle of the wake pulse while the mask is set. They also cover the flag when written with 1, the flag written with 0 in the same cycle as an event, the irq gating by the mask, the reserved control bits, and the unused address.

// File: rtl/kbw_pkg.sv
`timescale 1ns/1ps
package kbw_pkg;

    localparam int unsigned KBW_PINS       = 8;
    localparam int unsigned KBW_GROUP_PINS = 4;

    // Writable control bits: group enable and the four individual enables
    localparam logic [7:0] KBW_CTRL_WMASK = 8'hF1;

    localparam logic [1:0] KBW_A_CTRL = 2'd0;
    localparam logic [1:0] KBW_A_FLAG = 2'd1;
    localparam logic [1:0] KBW_A_MASK = 2'd2;

    typedef enum logic [1:0] {
        EDG_START = 2'd0,
        EDG_HIGH  = 2'd1,
        EDG_LOW   = 2'd2
    } edge_state_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;

    // Expand control bits into one enable per pin
    function automatic logic [KBW_PINS-1:0] pin_enables(input logic [7:0] ctrl);
        logic [KBW_PINS-1:0] en;
        for (int i = 0; i < int'(KBW_PINS); i++) begin
            if (i < int'(KBW_GROUP_PINS)) en[i] = ctrl[0];
            else                          en[i] = ctrl[i];
        end
        return en;
    endfunction

endpackage

// File: rtl/kbw_sync.sv
`timescale 1ns/1ps
module kbw_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/kbw_edge_fsm.sv
`timescale 1ns/1ps
module kbw_edge_fsm
    import kbw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall
);

    edge_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDG_START;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDG_START: state_d = level ? EDG_HIGH : EDG_LOW;
            EDG_HIGH:  if (!level) state_d = EDG_LOW;
            EDG_LOW:   if (level)  state_d = EDG_HIGH;
            default:   state_d = EDG_START;
        endcase
    end

    // Output process: the EDG_HIGH -> EDG_LOW transition emits the pulse
    always_comb begin
        fall = 1'b0;
        unique case (state_q)
            EDG_HIGH: fall = !level;
            default:  fall = 1'b0;
        endcase
    end

    // R6: a pulse never lasts two cycles
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

    // R5: a pulse needs the level to have been high one cycle earlier
    p_fall_from_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> ($past(level) && !level));

endmodule

// File: rtl/kbw_regs.sv
`timescale 1ns/1ps
module kbw_regs
    import kbw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  logic       event_any,
    output logic [7:0] ctrl,
    output logic       flag,
    output logic       mask,
    output logic [7:0] rdata
);

    logic [7:0]  ctrl_q;
    logic        mask_q;
    flag_state_e flag_q, flag_d;
    logic        sw_clear;

    assign sw_clear = wr_en && (addr == KBW_A_FLAG) && !wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 8'h00;
            mask_q <= 1'b1;
        end else if (wr_en) begin
            if (addr == KBW_A_CTRL) ctrl_q <= wdata & KBW_CTRL_WMASK;
            if (addr == KBW_A_MASK) mask_q <= wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= FLG_IDLE;
        else        flag_q <= flag_d;
    end

    // A detection takes priority over a clear in the same cycle
    always_comb begin
        flag_d = flag_q;
        unique case (flag_q)
            FLG_IDLE: if (event_any) flag_d = FLG_PEND;
            FLG_PEND: if (sw_clear && !event_any) flag_d = FLG_IDLE;
            default:  flag_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag = (flag_q == FLG_PEND);
        unique case (addr)
            KBW_A_CTRL: rdata = ctrl_q;
            KBW_A_FLAG: rdata = {7'd0, flag};
            KBW_A_MASK: rdata = {7'd0, mask_q};
            default:    rdata = 8'h00;
        endcase
    end

    assign ctrl = ctrl_q;
    assign mask = mask_q;

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        event_any |=> flag);

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && !event_any) |=> !flag);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && event_any) |=> flag);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == KBW_A_CTRL) |-> (rdata[3:1] == 3'b000));

endmodule

// File: rtl/kbw_top.sv
`timescale 1ns/1ps
module kbw_top
    import kbw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] key_pins,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       wake
);

    logic [KBW_PINS-1:0] pins_s;
    logic [KBW_PINS-1:0] fall_vec;
    logic [KBW_PINS-1:0] pin_en;
    logic [7:0]          ctrl;
    logic                flag;
    logic                mask;

    kbw_sync #(.WIDTH(KBW_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (key_pins),
        .dout (pins_s)
    );

    for (genvar p = 0; p < int'(KBW_PINS); p++) begin : g_pin
        kbw_edge_fsm u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .level(pins_s[p]),
            .fall (fall_vec[p])
        );
    end

    assign pin_en = pin_enables(ctrl);
    assign wake   = |(fall_vec & pin_en);

    kbw_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .event_any(wake),
        .ctrl     (ctrl),
        .flag     (flag),
        .mask     (mask),
        .rdata    (rdata)
    );

    assign irq = flag && !mask;

    // R3/R4: no wake unless some enable bit is set
    p_wake_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (ctrl[0] || (|ctrl[7:4])));

    p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !mask && !(wr_en && addr == KBW_A_MASK)) |=> irq);

endmodule

// File: tb/test_kbw_top.sv
`timescale 1ns/1ps
module test_kbw_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] key_pins = 8'hFF;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    logic       wake;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5ns clk = ~clk;

    kbw_top i_kbw_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_pins(key_pins),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq     (irq),
        .wake    (wake)
    );

    // {ctrl, start pins, end pins}
    localparam logic [23:0] VEC [10] = '{
        {8'h01, 8'hFF, 8'hFE},
        {8'h01, 8'hFF, 8'hF7},
        {8'h01, 8'hFF, 8'hEF},
        {8'h10, 8'hFF, 8'hEF},
        {8'h10, 8'hFF, 8'hDF},
        {8'h80, 8'hFF, 8'h7F},
        {8'hF1, 8'h00, 8'hFF},
        {8'h00, 8'hFF, 8'h00},
        {8'hF0, 8'hFF, 8'hF0},
        {8'h41, 8'hF0, 8'hBF}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1ns;
        d = rdata;
    endtask

    task automatic settle(input logic [7:0] pins);
        @(negedge clk);
        key_pins = pins;
        repeat (6) @(negedge clk);
    endtask

    function automatic bit expect_event(input logic [7:0] c, input logic [7:0] s, input logic [7:0] e);
        logic [7:0] en;
        en = {c[7:4], {4{c[0]}}};
        return ((s & ~e & en) != 8'h00);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=0x0 expected=0x1");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd0, rd); check(rd == 8'h00, "R1 ctrl", rd, 8'h00);
        reg_read(2'd1, rd); check(rd == 8'h00, "R1 flag", rd, 8'h00);
        reg_read(2'd2, rd); check(rd == 8'h01, "R1 mask", rd, 8'h01);
        check(!irq && !wake, "R1 irq/wake", {irq, wake}, 0);

        // R2 reserved bits
        reg_write(2'd0, 8'hFF);
        reg_read(2'd0, rd); check(rd == 8'hF1, "R2 ctrl readback", rd, 8'hF1);

        // R10 unused address
        reg_write(2'd3, 8'hFF);
        reg_read(2'd3, rd); check(rd == 8'h00, "R10 addr3 read", rd, 8'h00);
        reg_read(2'd2, rd); check(rd == 8'h01, "R10 mask unchanged", rd, 8'h01);
        reg_read(2'd0, rd); check(rd == 8'hF1, "R10 ctrl unchanged", rd, 8'hF1);

        // Table: R3 R4 R5 R6 R7
        for (int v = 0; v < 10; v++) begin
            logic [7:0] c, s, e;
            int pulses;
            bit exp_ev;
            {c, s, e} = VEC[v];
            exp_ev = expect_event(c, s, e);
            reg_write(2'd0, c);
            settle(s);
            reg_write(2'd1, 8'h00);
            reg_read(2'd1, rd);
            check(rd == 8'h00, "R7 flag cleared", rd, 8'h00);
            pulses = 0;
            @(negedge clk);
            key_pins = e;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (wake) pulses++;
            end
            check(pulses == int'(exp_ev), "R3 R4 R5 R6 wake pulses", pulses, int'(exp_ev));
            reg_read(2'd1, rd);
            check(rd[0] == exp_ev, "R3 R4 R5 R7 flag", rd, int'(exp_ev));
        end

        // R6 exact timing with mask set (R9 wake unmasked)
        reg_write(2'd0, 8'h01);
        settle(8'hFF);
        reg_write(2'd1, 8'h00);
        @(negedge clk);
        key_pins = 8'hFE;
        @(negedge clk); check(!wake, "R6 no wake after 1 edge", wake, 0);
        @(negedge clk); check(wake, "R6 R9 wake after 2 edges while masked", wake, 1);
        @(negedge clk); check(!wake, "R6 wake one cycle", wake, 0);
        reg_read(2'd1, rd); check(rd[0], "R7 flag set", rd, 1);
        check(!irq, "R9 irq masked", irq, 0);

        // R9 unmask
        reg_write(2'd2, 8'h00);
        #1ns; check(irq, "R9 irq unmasked", irq, 1);
        // R7 writing 1 has no effect, writing 0 clears
        reg_write(2'd1, 8'h01);
        reg_read(2'd1, rd); check(rd[0], "R7 write 1 keeps flag", rd, 1);
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, rd); check(!rd[0], "R7 write 0 clears", rd, 0);
        check(!irq, "R9 irq drops with flag", irq, 0);
        reg_write(2'd1, 8'h01);
        reg_read(2'd1, rd); check(!rd[0], "R7 write 1 does not set", rd, 0);

        // R8 clear coincident with event
        settle(8'hFF);
        @(negedge clk);
        key_pins = 8'hFD;
        @(negedge clk);
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, rd); check(rd[0], "R8 event beats clear", rd, 1);
        check(irq, "R8 R9 irq after coincident clear", irq, 1);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule